// File: doc/BRIEF.md
# Host Handshake Trigger Sequencer

This block sits between a device-side microcontroller and the host-facing status logic of a packet-command storage device. Firmware writes one-cycle trigger bits into a small command port. Each bit starts a fixed hardware sequence that updates the host-visible status flags (busy, data request, device ready, corrected, error-check), the interrupt reason code, the command/data select flag, the transfer enable and the transfer byte count. Firmware never has to step these flags by hand.

An automatic transfer started in programmed-I/O mode does not finish when the trigger is processed. The block then watches an active-low FIFO-ready input. When that input goes low, the block raises data request, drops busy and interrupts the host, without any help from firmware. In DMA mode the same trigger only does the set-up part of this work. The handshake-only trigger is refused in DMA mode. A status-completion trigger copies staged status bits into the live flags. A clear trigger pulses the packet FIFO clear line. Triggers that arrive in the same write are held as pending and served one at a time in a fixed priority order.

Top module: `hhs_trigger_seq`

## Requirements
- R1: Trigger bit positions in `trig_wdata` are: bit 3 clear packet FIFO, bit 2 automatic transfer, bit 1 data-request handshake, bit 0 status completion. Each written bit is acted on exactly once, and its effect shows after the second rising edge from the write. The clear trigger drives `pkt_fifo_clr` high for exactly one cycle.
- R2: A synchronous reset drives every output to 0 and leaves no sequence pending.
- R3: The automatic-transfer trigger, in either mode, sets `busy` and `xfer_en` to 1 and sets `cmd_data_sel` equal to `xfer_dir`. It loads `int_reason` with 02h when `xfer_dir` is 0 and with 00h when it is 1.
- R4: When `auto_bc_en` is 1, the automatic-transfer trigger loads `byte_count` with ((`word_cnt` + 1) × 2) mod 2^16. When `auto_bc_en` is 0, it leaves `byte_count` unchanged.
- R5: A high `bc_we` loads `bc_wdata` into `byte_count` on the next edge. This is how firmware sets a multi-block count. If an automatic load happens on the same edge, the automatic load wins.
- R6: After an automatic transfer starts in programmed-I/O mode, `drq` stays 0, `busy` stays 1 and `host_irq` stays 0 for as long as `fifo_rdy_n` is high.
- R7: On the first edge where the block samples `fifo_rdy_n` low during that wait, it sets `drq`. It clears `busy` on the next edge and sets `host_irq` on the edge after that.
- R8: An automatic transfer started in DMA mode (`pio_mode` = 0) never raises `drq` or `host_irq` and never clears `busy`, whatever `fifo_rdy_n` does.
- R9: In programmed-I/O mode the handshake trigger sets `drq`, then clears `busy` one edge later, then sets `host_irq` one edge after that. In DMA mode the handshake trigger is ignored.
- R10: The status-completion trigger copies `shadow_check`, `shadow_corr` and `shadow_drdy` into `check`, `corr` and `drdy`, and it loads `int_reason` with 03h.
- R11: Pending triggers are served one per cycle, in this order: clear, status completion, handshake, automatic transfer. No trigger is served while a handshake completion is in progress.
- R12: `host_irq` clears on the edge after `host_stat_rd` is high. If the interrupt is set on the same edge, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Trigger write strobe |
| trig_wdata | input | 4 | Trigger bits (see R1) |
| pio_mode | input | 1 | 1 = programmed I/O, 0 = DMA |
| xfer_dir | input | 1 | Data direction bit; selects the reason code and the command/data flag |
| auto_bc_en | input | 1 | Enables the automatic byte-count load |
| word_cnt | input | CNT_W | Transfer word count for the automatic byte count |
| bc_we | input | 1 | Firmware byte-count write strobe |
| bc_wdata | input | CNT_W | Firmware byte-count value |
| fifo_rdy_n | input | 1 | Data FIFO ready, active low |
| shadow_check | input | 1 | Staged error-check bit |
| shadow_corr | input | 1 | Staged corrected-data bit |
| shadow_drdy | input | 1 | Staged device-ready bit |
| host_stat_rd | input | 1 | Host read of the status register |
| pkt_fifo_clr | output | 1 | One-cycle packet FIFO clear pulse |
| busy | output | 1 | Busy status flag |
| drq | output | 1 | Data request status flag |
| drdy | output | 1 | Device ready status flag |
| corr | output | 1 | Corrected data status flag |
| check | output | 1 | Error-check status flag |
| int_reason | output | RSN_W | Interrupt reason code |
| cmd_data_sel | output | 1 | Command/data select flag |
| xfer_en | output | 1 | Data transfer enable |
| byte_count | output | CNT_W | Transfer byte count |
| host_irq | output | 1 | Host interrupt request |

## Verification
The bench runs every combination of mode, direction and auto-count enable against word counts that include zero and the all-ones value. A design that dropped the carry of the count would wrap too early; one that ignored the enable would overwrite a firmware count. It follows the programmed-I/O completion one cycle at a time. This catches a design that raised the interrupt before dropping busy, or one that finished without the FIFO-ready input. DMA runs with the FIFO ready confirm that no completion leaks through. A write of all four triggers at once is traced edge by edge, which exposes a wrong priority, two triggers served together, or a trigger served during a completion. The bench also collides the firmware count write with the automatic load, and the status read with the interrupt set.

// File: rtl/hhs_pkg.sv
package hhs_pkg;
  // trigger bit positions, decoded by firmware writes
  localparam int TRIG_N  = 4;
  localparam int TB_STAT = 0;
  localparam int TB_DRQ  = 1;
  localparam int TB_AUTO = 2;
  localparam int TB_CLR  = 3;

  // service order, highest first
  localparam int PRIO_ORDER [TRIG_N] = '{TB_CLR, TB_STAT, TB_DRQ, TB_AUTO};

  localparam int RSN_W = 8;
  localparam logic [RSN_W-1:0] RSN_DIR0 = 8'h02;
  localparam logic [RSN_W-1:0] RSN_DIR1 = 8'h00;
  localparam logic [RSN_W-1:0] RSN_DONE = 8'h03;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT_FIFO,
    SQ_CLR_BUSY,
    SQ_RAISE_IRQ
  } sq_state_t;
endpackage

// File: rtl/hhs_trig_arb.sv
module hhs_trig_arb
  import hhs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TRIG_N-1:0] wr_bits,
  input  logic              accept,
  output logic [TRIG_N-1:0] grant
);
  logic [TRIG_N-1:0] pend_q;
  logic [TRIG_N-1:0] ord;
  logic [TRIG_N-1:0] ord_grant;

  // pending bits laid out in service order
  for (genvar k = 0; k < TRIG_N; k++) begin : g_ord
    assign ord[k] = pend_q[PRIO_ORDER[k]];
    assign grant[PRIO_ORDER[k]] = ord_grant[k];
  end

  // lowest set bit of ord is the highest-priority pending trigger
  always_comb begin
    ord_grant = '0;
    if (accept) begin
      ord_grant = ord & (~ord + {{(TRIG_N-1){1'b0}}, 1'b1});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | (wr_en ? wr_bits : '0);
    end
  end
endmodule

// File: rtl/hhs_bytecount.sv
module hhs_bytecount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_auto,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic             fw_we,
  input  logic [CNT_W-1:0] fw_data,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] words_plus;
  logic [CNT_W-1:0] auto_bytes;

  assign words_plus = word_cnt + ONE;
  assign auto_bytes = {words_plus[CNT_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_auto) begin
      count <= auto_bytes;
    end else if (fw_we) begin
      count <= fw_data;
    end
  end
endmodule

// File: rtl/hhs_seq_core.sv
module hhs_seq_core
  import hhs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_N-1:0] grant,
  input  logic              pio_mode,
  input  logic              xfer_dir,
  input  logic              fifo_rdy_n,
  input  logic              shadow_check,
  input  logic              shadow_corr,
  input  logic              shadow_drdy,
  input  logic              host_stat_rd,
  output logic              accept,
  output logic              pkt_fifo_clr,
  output logic              busy,
  output logic              drq,
  output logic              drdy,
  output logic              corr,
  output logic              check,
  output logic [RSN_W-1:0]  int_reason,
  output logic              cmd_data_sel,
  output logic              xfer_en,
  output logic              host_irq
);
  sq_state_t st_q;
  logic      fifo_hit;

  assign fifo_hit = (st_q == SQ_WAIT_FIFO) && !fifo_rdy_n;
  assign accept   = (st_q == SQ_IDLE) || ((st_q == SQ_WAIT_FIFO) && fifo_rdy_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= SQ_IDLE;
      pkt_fifo_clr <= 1'b0;
      busy         <= 1'b0;
      drq          <= 1'b0;
      drdy         <= 1'b0;
      corr         <= 1'b0;
      check        <= 1'b0;
      int_reason   <= '0;
      cmd_data_sel <= 1'b0;
      xfer_en      <= 1'b0;
      host_irq     <= 1'b0;
    end else begin
      pkt_fifo_clr <= grant[TB_CLR];

      if (st_q == SQ_RAISE_IRQ) begin
        host_irq <= 1'b1;
      end else if (host_stat_rd) begin
        host_irq <= 1'b0;
      end

      unique case (st_q)
        SQ_IDLE, SQ_WAIT_FIFO: begin
          if (fifo_hit) begin
            drq  <= 1'b1;
            st_q <= SQ_CLR_BUSY;
          end else begin
            if (grant[TB_STAT]) begin
              check      <= shadow_check;
              corr       <= shadow_corr;
              drdy       <= shadow_drdy;
              int_reason <= RSN_DONE;
            end
            if (grant[TB_DRQ] && pio_mode) begin
              drq  <= 1'b1;
              st_q <= SQ_CLR_BUSY;
            end
            if (grant[TB_AUTO]) begin
              busy         <= 1'b1;
              xfer_en      <= 1'b1;
              cmd_data_sel <= xfer_dir;
              int_reason   <= xfer_dir ? RSN_DIR1 : RSN_DIR0;
              st_q         <= pio_mode ? SQ_WAIT_FIFO : SQ_IDLE;
            end
          end
        end
        SQ_CLR_BUSY: begin
          busy <= 1'b0;
          st_q <= SQ_RAISE_IRQ;
        end
        SQ_RAISE_IRQ: begin
          st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hhs_trigger_seq.sv
module hhs_trigger_seq
  import hhs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_we,
  input  logic [3:0]       trig_wdata,
  input  logic             pio_mode,
  input  logic             xfer_dir,
  input  logic             auto_bc_en,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic             bc_we,
  input  logic [CNT_W-1:0] bc_wdata,
  input  logic             fifo_rdy_n,
  input  logic             shadow_check,
  input  logic             shadow_corr,
  input  logic             shadow_drdy,
  input  logic             host_stat_rd,
  output logic             pkt_fifo_clr,
  output logic             busy,
  output logic             drq,
  output logic             drdy,
  output logic             corr,
  output logic             check,
  output logic [7:0]       int_reason,
  output logic             cmd_data_sel,
  output logic             xfer_en,
  output logic [CNT_W-1:0] byte_count,
  output logic             host_irq
);
  logic [TRIG_N-1:0] grant;
  logic              accept;
  logic              load_auto;

  assign load_auto = grant[TB_AUTO] & auto_bc_en;

  hhs_trig_arb u_arb (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (trig_we),
    .wr_bits (trig_wdata),
    .accept  (accept),
    .grant   (grant)
  );

  hhs_seq_core u_core (
    .clk          (clk),
    .rst          (rst),
    .grant        (grant),
    .pio_mode     (pio_mode),
    .xfer_dir     (xfer_dir),
    .fifo_rdy_n   (fifo_rdy_n),
    .shadow_check (shadow_check),
    .shadow_corr  (shadow_corr),
    .shadow_drdy  (shadow_drdy),
    .host_stat_rd (host_stat_rd),
    .accept       (accept),
    .pkt_fifo_clr (pkt_fifo_clr),
    .busy         (busy),
    .drq          (drq),
    .drdy         (drdy),
    .corr         (corr),
    .check        (check),
    .int_reason   (int_reason),
    .cmd_data_sel (cmd_data_sel),
    .xfer_en      (xfer_en),
    .host_irq     (host_irq)
  );

  hhs_bytecount #(.CNT_W(CNT_W)) u_bc (
    .clk       (clk),
    .rst       (rst),
    .load_auto (load_auto),
    .word_cnt  (word_cnt),
    .fw_we     (bc_we),
    .fw_data   (bc_wdata),
    .count     (byte_count)
  );
endmodule

// File: rtl/hhs_trigger_seq_chk.sv
module hhs_trigger_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_stat_rd,
  input logic       busy,
  input logic       drq,
  input logic       xfer_en,
  input logic       host_irq,
  input logic [7:0] int_reason
);
  // R7
  irq_after_drq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> drq);

  // R7
  irq_busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> (!busy && !$past(busy)));

  // R12
  irq_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(host_irq) && !$past(rst)) |-> $past(host_stat_rd));

  // R3
  busy_with_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> xfer_en);

  // R10
  reason_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (int_reason == 8'h00) || (int_reason == 8'h02) || (int_reason == 8'h03));
endmodule

bind hhs_trigger_seq hhs_trigger_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_stat_rd (host_stat_rd),
  .busy         (busy),
  .drq          (drq),
  .xfer_en      (xfer_en),
  .host_irq     (host_irq),
  .int_reason   (int_reason)
);

// File: tb/hhs_trigger_seq_bench.sv
`timescale 1ns/1ps
module hhs_trigger_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_we = 1'b0;
  logic [3:0]  trig_wdata = '0;
  logic        pio_mode = 1'b0;
  logic        xfer_dir = 1'b0;
  logic        auto_bc_en = 1'b0;
  logic [15:0] word_cnt = '0;
  logic        bc_we = 1'b0;
  logic [15:0] bc_wdata = '0;
  logic        fifo_rdy_n = 1'b1;
  logic        shadow_check = 1'b0;
  logic        shadow_corr = 1'b0;
  logic        shadow_drdy = 1'b0;
  logic        host_stat_rd = 1'b0;
  logic        pkt_fifo_clr, busy, drq, drdy, corr, check;
  logic [7:0]  int_reason;
  logic        cmd_data_sel, xfer_en, host_irq;
  logic [15:0] byte_count;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hhs_trigger_seq u_hhs_trigger_seq (
    .clk(clk), .rst(rst), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .pio_mode(pio_mode), .xfer_dir(xfer_dir), .auto_bc_en(auto_bc_en),
    .word_cnt(word_cnt), .bc_we(bc_we), .bc_wdata(bc_wdata),
    .fifo_rdy_n(fifo_rdy_n), .shadow_check(shadow_check),
    .shadow_corr(shadow_corr), .shadow_drdy(shadow_drdy),
    .host_stat_rd(host_stat_rd), .pkt_fifo_clr(pkt_fifo_clr), .busy(busy),
    .drq(drq), .drdy(drdy), .corr(corr), .check(check),
    .int_reason(int_reason), .cmd_data_sel(cmd_data_sel), .xfer_en(xfer_en),
    .byte_count(byte_count), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    rst = 1'b1; trig_we = 1'b0; trig_wdata = '0; pio_mode = 1'b0;
    xfer_dir = 1'b0; auto_bc_en = 1'b0; word_cnt = '0; bc_we = 1'b0;
    bc_wdata = '0; fifo_rdy_n = 1'b1; host_stat_rd = 1'b0;
    shadow_check = 1'b0; shadow_corr = 1'b0; shadow_drdy = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_trig(input logic [3:0] b);
    trig_we = 1'b1; trig_wdata = b;
    @(negedge clk);
    trig_we = 1'b0; trig_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] wl [4];
    logic [15:0] exp_bc;
    wl[0] = 16'h0000; wl[1] = 16'h0007; wl[2] = 16'h1234; wl[3] = 16'hFFFF;

    @(negedge clk);
    do_reset();
    // R2 reset state
    chk("R2 busy", busy, 0); chk("R2 drq", drq, 0); chk("R2 irq", host_irq, 0);
    chk("R2 xfer_en", xfer_en, 0); chk("R2 reason", int_reason, 0);
    chk("R2 bc", byte_count, 0); chk("R2 clr", pkt_fifo_clr, 0);
    chk("R2 flags", {cmd_data_sel, drdy, corr, check}, 0);

    // sweep automatic transfer over mode, direction, count option, word count
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 2; d++) begin
        for (int a = 0; a < 2; a++) begin
          for (int w = 0; w < 4; w++) begin
            do_reset();
            pio_mode = p[0]; xfer_dir = d[0]; auto_bc_en = a[0]; word_cnt = wl[w];
            bc_we = 1'b1; bc_wdata = 16'hA5A5;
            @(negedge clk);
            bc_we = 1'b0;
            chk("R5 fw count", byte_count, 16'hA5A5);
            wr_trig(4'b0100);
            @(negedge clk);
            chk("R3 busy", busy, 1);
            chk("R3 xfer_en", xfer_en, 1);
            chk("R3 cmd_data_sel", cmd_data_sel, d);
            chk("R3 reason", int_reason, d ? 8'h00 : 8'h02);
            exp_bc = wl[w] + 16'd1;
            exp_bc = exp_bc << 1;
            chk("R4 byte count", byte_count, a ? exp_bc : 16'hA5A5);
            if (p == 1) begin
              repeat (3) @(negedge clk);
              chk("R6 wait drq", drq, 0);
              chk("R6 wait busy", busy, 1);
              chk("R6 wait irq", host_irq, 0);
              fifo_rdy_n = 1'b0;
              @(negedge clk);
              chk("R7 step1 drq", {drq, busy, host_irq}, 3'b110);
              @(negedge clk);
              chk("R7 step2 busy", {drq, busy, host_irq}, 3'b100);
              @(negedge clk);
              chk("R7 step3 irq", {drq, busy, host_irq}, 3'b101);
            end else begin
              fifo_rdy_n = 1'b0;
              repeat (5) @(negedge clk);
              chk("R8 dma no completion", {drq, busy, host_irq}, 3'b010);
            end
          end
        end
      end
    end

    // R9 handshake trigger in PIO, with status read held high (R12 set wins)
    do_reset();
    pio_mode = 1'b1; host_stat_rd = 1'b1;
    wr_trig(4'b0010);
    @(negedge clk);
    chk("R9 drq set", {drq, host_irq}, 2'b10);
    @(negedge clk);
    chk("R9 irq not yet", host_irq, 0);
    @(negedge clk);
    chk("R12 set wins", host_irq, 1);
    @(negedge clk);
    chk("R12 read clears", host_irq, 0);
    host_stat_rd = 1'b0;
    wr_trig(4'b0010);
    repeat (4) @(negedge clk);
    chk("R12 irq holds", host_irq, 1);
    host_stat_rd = 1'b1;
    @(negedge clk);
    host_stat_rd = 1'b0;
    chk("R12 pulse clears", host_irq, 0);

    // R9 handshake trigger ignored in DMA
    do_reset();
    wr_trig(4'b0010);
    repeat (5) @(negedge clk);
    chk("R9 dma ignored", {drq, busy, host_irq}, 3'b000);

    // R10 status completion over every staged pattern
    do_reset();
    for (int s = 0; s < 8; s++) begin
      shadow_check = s[0]; shadow_corr = s[1]; shadow_drdy = s[2];
      wr_trig(4'b0001);
      @(negedge clk);
      chk("R10 status copy", {drdy, corr, check}, s[2:0]);
      chk("R10 reason", int_reason, 8'h03);
    end
    shadow_check = 1'b0; shadow_corr = 1'b0; shadow_drdy = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 trigger served once", {drdy, corr, check}, 3'b111);

    // R1 clear pulse
    wr_trig(4'b1000);
    @(negedge clk);
    chk("R1 clear pulse", pkt_fifo_clr, 1);
    @(negedge clk);
    chk("R1 clear one cycle", pkt_fifo_clr, 0);

    // R11 priority of a four-trigger write
    do_reset();
    pio_mode = 1'b1; shadow_check = 1'b1; shadow_corr = 1'b1; shadow_drdy = 1'b1;
    wr_trig(4'b1111);
    @(negedge clk);
    chk("R11 clear first", {pkt_fifo_clr, check}, 2'b10);
    @(negedge clk);
    chk("R11 status second", {pkt_fifo_clr, check, drq}, 3'b010);
    chk("R11 status reason", int_reason, 8'h03);
    @(negedge clk);
    chk("R11 handshake third", {drq, xfer_en}, 2'b10);
    @(negedge clk);
    chk("R11 held during completion", xfer_en, 0);
    @(negedge clk);
    chk("R11 irq before auto", {host_irq, xfer_en}, 2'b10);
    @(negedge clk);
    chk("R11 auto last", {busy, xfer_en}, 2'b11);
    chk("R11 auto reason", int_reason, 8'h02);

    // R5 automatic load beats firmware write on the same edge
    do_reset();
    auto_bc_en = 1'b1; word_cnt = 16'd9;
    trig_we = 1'b1; trig_wdata = 4'b0100;
    @(negedge clk);
    trig_we = 1'b0; trig_wdata = '0;
    bc_we = 1'b1; bc_wdata = 16'h7777;
    @(negedge clk);
    bc_we = 1'b0;
    chk("R5 auto wins", byte_count, 16'd20);
    @(negedge clk);
    chk("R5 count holds", byte_count, 16'd20);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule